// File: doc/BRIEF.md
# Segment Register Load Protection Checker

This block decides whether a selector may be loaded into one of eight segment or system registers. The eight targets are the code, stack and four data registers, plus the local-table and task registers. For each request it is given the selector, the target code, the current privilege level, the limit of the descriptor table the selector points into, and the type, system/non-system flag, privilege and present fields of the descriptor already fetched.

It applies its checks in a fixed order: null selector, table limit, descriptor type, privilege, then presence. It returns exactly one outcome: accept, general-protection fault, not-present fault or stack fault. The outcome comes with the selector to report to the fault handler. Reading the descriptor from memory and updating the hidden register state are done elsewhere.

The checks are combinational. The outcome is registered, so it appears one clock after the request. The privilege tests compare against the effective level, which is the numerically larger of the current level and the selector's requested level.

Top module: `seg_load_checker`

## Requirements
- R1: A request sampled with `reqValid` high produces `resValid` high on the next clock, with exactly one of `accept`, `gpFault`, `npFault` and `ssFault` set. A cycle without a request yields all five outputs low and `faultSel` zero. An accept reports `faultSel` zero.
- R2: Selector bits 15:3 are the descriptor index, bit 2 is the table indicator and bits 1:0 are the requested level (RPL). The selector is null when bits 15:2 are all zero. Target codes are: 0 code (CS), 1 stack (SS), 2 to 5 data (DS, ES, FS, GS), 6 local table (LDTR), 7 task (TR).
- R3: A null selector is accepted for targets 2 to 6. For targets 0, 1 and 7 it raises `gpFault` with `faultSel` zero. No other check applies to a null selector.
- R4: A non-null selector whose last descriptor byte, index×8+7, exceeds `tableLimit` raises `gpFault` with `faultSel` equal to the selector. This check takes priority over the type, privilege and present checks.
- R5: The effective level (EPL) is max(CPL, RPL). A privilege failure raises `gpFault` with the selector as `faultSel`.
- R6: Descriptor type bits: with `descS`=1, type bit 3 set means code, and then bit 2 is conforming and bit 1 is readable. Type bit 3 clear means data, and then bit 1 is writable. The code target needs a code descriptor. If nonconforming, DPL must equal CPL and RPL must be at most CPL. If conforming, DPL must be at most CPL. Any type failure raises `gpFault`.
- R7: The stack target needs a writable data descriptor with DPL equal to EPL. Otherwise it raises `gpFault`.
- R8: The data targets reject system descriptors and unreadable code with `gpFault`. They require EPL ≤ DPL, except for conforming code, which skips the privilege test.
- R9: The local-table target needs `descS`=0 with type 2. The task target needs `descS`=0 with type 1 or 9. Neither applies a privilege test. A type failure raises `gpFault`.
- R10: When every earlier check passes but `descPresent` is 0, the stack target raises `ssFault` and every other target raises `npFault`, with `faultSel` equal to the selector. A type or privilege failure on a non-present descriptor still raises `gpFault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| selector | input | SEL_W | Selector being loaded |
| targetReg | input | 3 | Destination register code |
| cpl | input | 2 | Current privilege level |
| tableLimit | input | LIMIT_W | Byte limit of the referenced descriptor table |
| descType | input | 4 | Descriptor type field |
| descS | input | 1 | Descriptor non-system flag |
| descDpl | input | 2 | Descriptor privilege level |
| descPresent | input | 1 | Descriptor present flag |
| resValid | output | 1 | Result strobe, one cycle after the request |
| accept | output | 1 | Load permitted |
| gpFault | output | 1 | General-protection fault |
| npFault | output | 1 | Segment-not-present fault |
| ssFault | output | 1 | Stack fault |
| faultSel | output | SEL_W | Selector reported with a fault |

## Verification
The bench builds the block with its default 16-bit selector and 16-bit table limit. With those values the whole index range can be compared against every limit, including the last descriptor that still fits and the first one that does not. Random requests cover all eight targets, all CPL and RPL pairs and every type code. Directed cases pin down the null policy for each target and the order of the checks on non-present descriptors.

// File: rtl/seg_load_pkg.sv
package seg_load_pkg;
  typedef enum logic [2:0] {
    TGT_CS = 3'd0, TGT_SS = 3'd1, TGT_DS = 3'd2, TGT_ES = 3'd3,
    TGT_FS = 3'd4, TGT_GS = 3'd5, TGT_LDTR = 3'd6, TGT_TR = 3'd7
  } target_e;

  localparam logic [3:0] LDT_TYPE   = 4'd2;
  localparam logic [3:0] TSS16_TYPE = 4'd1;
  localparam logic [3:0] TSS32_TYPE = 4'd9;

  // facts the datapath derives for the control
  typedef struct packed {
    logic       isNull;
    logic       inLimit;
    logic       sFlag;
    logic [3:0] typeBits;
    logic       present;
    logic       dplEqEpl;
    logic       dplGeEpl;
    logic       dplEqCpl;
    logic       dplLeCpl;
    logic       rplLeCpl;
  } check_t;

  // decision strobes from the control
  typedef struct packed {
    logic acceptStb;
    logic gpStb;
    logic npStb;
    logic ssStb;
    logic zeroSel;
  } strobe_t;
endpackage

// File: rtl/seg_load_datapath.sv
module seg_load_datapath
  import seg_load_pkg::*;
#(
  parameter int SEL_W   = 16,
  parameter int LIMIT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reqValid,
  input  logic [SEL_W-1:0]   selector,
  input  logic [1:0]         cpl,
  input  logic [LIMIT_W-1:0] tableLimit,
  input  logic [3:0]         descType,
  input  logic               descS,
  input  logic [1:0]         descDpl,
  input  logic               descPresent,
  input  strobe_t            stb,
  output check_t             chk,
  output logic               resValid,
  output logic               accept,
  output logic               gpFault,
  output logic               npFault,
  output logic               ssFault,
  output logic [SEL_W-1:0]   faultSel
);
  localparam int CMP_W = ((SEL_W > LIMIT_W) ? SEL_W : LIMIT_W) + 1;

  logic [1:0]       rpl;
  logic [1:0]       epl;
  logic [CMP_W-1:0] lastByte;
  logic [CMP_W-1:0] limitExt;

  always_comb begin
    rpl      = selector[1:0];
    epl      = (rpl > cpl) ? rpl : cpl;
    lastByte = CMP_W'({selector[SEL_W-1:3], 3'b111});
    limitExt = CMP_W'(tableLimit);
    chk.isNull   = (selector[SEL_W-1:2] == '0);
    chk.inLimit  = (lastByte <= limitExt);
    chk.sFlag    = descS;
    chk.typeBits = descType;
    chk.present  = descPresent;
    chk.dplEqEpl = (descDpl == epl);
    chk.dplGeEpl = (descDpl >= epl);
    chk.dplEqCpl = (descDpl == cpl);
    chk.dplLeCpl = (descDpl <= cpl);
    chk.rplLeCpl = (rpl <= cpl);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resValid <= 1'b0;
      accept   <= 1'b0;
      gpFault  <= 1'b0;
      npFault  <= 1'b0;
      ssFault  <= 1'b0;
      faultSel <= '0;
    end else begin
      resValid <= reqValid;
      accept   <= reqValid & stb.acceptStb;
      gpFault  <= reqValid & stb.gpStb;
      npFault  <= reqValid & stb.npStb;
      ssFault  <= reqValid & stb.ssStb;
      if (reqValid && !stb.acceptStb && !stb.zeroSel)
        faultSel <= selector;
      else
        faultSel <= '0;
    end
  end
endmodule

// File: rtl/seg_load_control.sv
module seg_load_control
  import seg_load_pkg::*;
(
  input  logic [2:0] targetReg,
  input  check_t     chk,
  output strobe_t    stb
);
  logic nullOk, typeOk, privOk;
  logic isCodeDesc, conf, rwBit;

  always_comb begin
    isCodeDesc = chk.typeBits[3];
    conf       = chk.typeBits[2];
    rwBit      = chk.typeBits[1];
    nullOk = 1'b0;
    typeOk = 1'b0;
    privOk = 1'b1;
    case (target_e'(targetReg))
      TGT_CS: begin
        typeOk = chk.sFlag & isCodeDesc;
        privOk = conf ? chk.dplLeCpl : (chk.dplEqCpl & chk.rplLeCpl);
      end
      TGT_SS: begin
        typeOk = chk.sFlag & ~isCodeDesc & rwBit;
        privOk = chk.dplEqEpl;
      end
      TGT_DS, TGT_ES, TGT_FS, TGT_GS: begin
        nullOk = 1'b1;
        typeOk = chk.sFlag & (~isCodeDesc | rwBit);
        privOk = (isCodeDesc & conf) | chk.dplGeEpl;
      end
      TGT_LDTR: begin
        nullOk = 1'b1;
        typeOk = ~chk.sFlag & (chk.typeBits == LDT_TYPE);
      end
      default: begin
        typeOk = ~chk.sFlag & ((chk.typeBits == TSS16_TYPE) | (chk.typeBits == TSS32_TYPE));
      end
    endcase

    stb = '0;
    if (chk.isNull) begin
      if (nullOk) stb.acceptStb = 1'b1;
      else begin
        stb.gpStb   = 1'b1;
        stb.zeroSel = 1'b1;
      end
    end else if (!chk.inLimit || !typeOk || !privOk) begin
      stb.gpStb = 1'b1;
    end else if (!chk.present) begin
      if (targetReg == TGT_SS) stb.ssStb = 1'b1;
      else                     stb.npStb = 1'b1;
    end else begin
      stb.acceptStb = 1'b1;
    end
  end
endmodule

// File: rtl/seg_load_checker.sv
module seg_load_checker
  import seg_load_pkg::*;
#(
  parameter int SEL_W   = 16,
  parameter int LIMIT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reqValid,
  input  logic [SEL_W-1:0]   selector,
  input  logic [2:0]         targetReg,
  input  logic [1:0]         cpl,
  input  logic [LIMIT_W-1:0] tableLimit,
  input  logic [3:0]         descType,
  input  logic               descS,
  input  logic [1:0]         descDpl,
  input  logic               descPresent,
  output logic               resValid,
  output logic               accept,
  output logic               gpFault,
  output logic               npFault,
  output logic               ssFault,
  output logic [SEL_W-1:0]   faultSel
);
  check_t  chk;
  strobe_t stb;

  seg_load_datapath #(.SEL_W(SEL_W), .LIMIT_W(LIMIT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .selector(selector),
    .cpl(cpl), .tableLimit(tableLimit), .descType(descType), .descS(descS),
    .descDpl(descDpl), .descPresent(descPresent), .stb(stb), .chk(chk),
    .resValid(resValid), .accept(accept), .gpFault(gpFault),
    .npFault(npFault), .ssFault(ssFault), .faultSel(faultSel)
  );

  seg_load_control u_ctl (
    .targetReg(targetReg), .chk(chk), .stb(stb)
  );
endmodule

// File: rtl/seg_load_checker_sva.sv
module seg_load_checker_sva #(
  parameter int SEL_W   = 16,
  parameter int LIMIT_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reqValid,
  input logic [SEL_W-1:0]   selector,
  input logic [2:0]         targetReg,
  input logic [LIMIT_W-1:0] tableLimit,
  input logic               descPresent,
  input logic               resValid,
  input logic               accept,
  input logic               gpFault,
  input logic               npFault,
  input logic               ssFault,
  input logic [SEL_W-1:0]   faultSel
);
  localparam int CMP_W = ((SEL_W > LIMIT_W) ? SEL_W : LIMIT_W) + 1;
  logic selNull;
  logic overLimit;
  assign selNull   = (selector[SEL_W-1:2] == '0);
  assign overLimit = CMP_W'({selector[SEL_W-1:3], 3'b111}) > CMP_W'(tableLimit);

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> resValid);
  p_one_outcome_r1: assert property (@(posedge clk) disable iff (!rst_n)
    resValid |-> $countones({accept, gpFault, npFault, ssFault}) == 1);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !resValid |-> !accept && !gpFault && !npFault && !ssFault && faultSel == '0);
  p_null_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && selNull && targetReg >= 3'd2 && targetReg <= 3'd6) |=> accept);
  p_null_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && selNull && (targetReg <= 3'd1 || targetReg == 3'd7))
      |=> gpFault && faultSel == '0);
  p_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !selNull && overLimit) |=> gpFault && faultSel == $past(selector));
  p_stack_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ssFault |-> $past(targetReg) == 3'd1 && !$past(descPresent));
  p_np_not_stack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    npFault |-> $past(targetReg) != 3'd1 && !$past(descPresent));
endmodule

bind seg_load_checker seg_load_checker_sva #(.SEL_W(SEL_W), .LIMIT_W(LIMIT_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .selector(selector),
  .targetReg(targetReg), .tableLimit(tableLimit), .descPresent(descPresent),
  .resValid(resValid), .accept(accept), .gpFault(gpFault), .npFault(npFault),
  .ssFault(ssFault), .faultSel(faultSel)
);

// File: tb/sim_seg_load_checker.sv
`timescale 1ns/1ps
module sim_seg_load_checker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic [15:0] selector = '0;
  logic [2:0]  targetReg = '0;
  logic [1:0]  cpl = '0;
  logic [15:0] tableLimit = '0;
  logic [3:0]  descType = '0;
  logic        descS = 1'b0;
  logic [1:0]  descDpl = '0;
  logic        descPresent = 1'b0;
  logic        resValid, accept, gpFault, npFault, ssFault;
  logic [15:0] faultSel;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  seg_load_checker u0 (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .selector(selector),
    .targetReg(targetReg), .cpl(cpl), .tableLimit(tableLimit),
    .descType(descType), .descS(descS), .descDpl(descDpl),
    .descPresent(descPresent), .resValid(resValid), .accept(accept),
    .gpFault(gpFault), .npFault(npFault), .ssFault(ssFault), .faultSel(faultSel)
  );

  // expected outcome: {accept, gp, np, ss}
  function automatic logic [3:0] refOutcome(input logic [15:0] sel, input int tgt,
      input int c, input int lim, input logic [3:0] ty, input logic s,
      input int dpl, input logic p);
    int rpl, epl, last;
    logic nullOk, tOk, pOk;
    rpl = int'(sel[1:0]);
    epl = (rpl > c) ? rpl : c;
    last = int'(sel[15:3]) * 8 + 7;
    nullOk = (tgt >= 2 && tgt <= 6);
    tOk = 0; pOk = 1;
    if (tgt == 0) begin
      tOk = s && ty[3];
      pOk = ty[2] ? (dpl <= c) : (dpl == c && rpl <= c);
    end else if (tgt == 1) begin
      tOk = s && !ty[3] && ty[1];
      pOk = (dpl == epl);
    end else if (tgt <= 5) begin
      tOk = s && (!ty[3] || ty[1]);
      pOk = (ty[3] && ty[2]) || (epl <= dpl);
    end else if (tgt == 6) tOk = !s && ty == 4'd2;
    else tOk = !s && (ty == 4'd1 || ty == 4'd9);
    if (sel[15:2] == 0) return nullOk ? 4'b1000 : 4'b0100;
    if (last > lim || !tOk || !pOk) return 4'b0100;
    if (!p) return (tgt == 1) ? 4'b0001 : 4'b0010;
    return 4'b1000;
  endfunction

  task automatic check(input string tag, input logic cond, input string msg);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic runReq(input string tag, input logic [15:0] sel, input int tgt,
      input int c, input int lim, input logic [3:0] ty, input logic s,
      input int dpl, input logic p);
    logic [3:0] exp;
    logic [15:0] expSel;
    @(negedge clk);
    selector = sel; targetReg = 3'(tgt); cpl = 2'(c); tableLimit = 16'(lim);
    descType = ty; descS = s; descDpl = 2'(dpl); descPresent = p;
    reqValid = 1'b1;
    exp = refOutcome(sel, tgt, c, lim, ty, s, dpl, p);
    expSel = (exp[3] || (sel[15:2] == 0)) ? 16'h0 : sel;
    @(negedge clk);
    reqValid = 1'b0;
    check(tag, resValid && {accept, gpFault, npFault, ssFault} == exp,
      $sformatf("sel=%h tgt=%0d outcome actual=%b expected=%b valid=%b",
        sel, tgt, {accept, gpFault, npFault, ssFault}, exp, resValid));
    check(tag, faultSel == expSel,
      $sformatf("faultSel actual=%h expected=%h", faultSel, expSel));
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset / idle state
    check("R1", !resValid && !accept && !gpFault && !npFault && !ssFault && faultSel == 0,
      $sformatf("idle actual=%b%b%b%b%b expected=00000", resValid, accept, gpFault, npFault, ssFault));
    // R3 null selector per target (RPL bits nonzero still null)
    for (int t = 0; t < 8; t++) runReq("R3", 16'h0003, t, 0, 16'hFFFF, 4'h3, 1, 3, 1);
    // R4 limit boundary: index 4 ends at byte 39
    runReq("R4", 16'h0020, 2, 0, 39, 4'h3, 1, 3, 1);
    runReq("R4", 16'h0020, 2, 0, 38, 4'h3, 1, 3, 1);
    runReq("R4", 16'hFFF8, 2, 0, 16'hFFFF, 4'h2, 1, 3, 1);
    runReq("R4", 16'h0028, 1, 0, 20, 4'h2, 1, 0, 0);
    // R5 effective level from RPL
    runReq("R5", 16'h000B, 2, 0, 255, 4'h2, 1, 2, 1);
    runReq("R5", 16'h000A, 2, 3, 255, 4'h2, 1, 2, 1);
    // R6 code target
    runReq("R6", 16'h0008, 0, 1, 255, 4'hA, 1, 1, 1);
    runReq("R6", 16'h000A, 0, 1, 255, 4'hA, 1, 1, 1);
    runReq("R6", 16'h0008, 0, 3, 255, 4'hE, 1, 1, 1);
    runReq("R6", 16'h0008, 0, 0, 255, 4'h2, 1, 0, 1);
    // R7 stack target
    runReq("R7", 16'h0012, 1, 2, 255, 4'h2, 1, 2, 1);
    runReq("R7", 16'h0012, 1, 2, 255, 4'h0, 1, 2, 1);
    runReq("R7", 16'h0012, 1, 1, 255, 4'h2, 1, 1, 1);
    // R8 data targets
    runReq("R8", 16'h0018, 3, 3, 255, 4'hA, 1, 3, 1);
    runReq("R8", 16'h0018, 4, 3, 255, 4'h8, 1, 3, 1);
    runReq("R8", 16'h0018, 5, 3, 255, 4'hE, 1, 0, 1);
    runReq("R8", 16'h0018, 2, 0, 255, 4'h2, 0, 3, 1);
    // R9 system targets
    runReq("R9", 16'h0020, 6, 3, 255, 4'h2, 0, 0, 1);
    runReq("R9", 16'h0020, 6, 0, 255, 4'h2, 1, 0, 1);
    runReq("R9", 16'h0020, 7, 3, 255, 4'h9, 0, 0, 1);
    runReq("R9", 16'h0020, 7, 0, 255, 4'hB, 0, 0, 1);
    // R10 presence ordering
    runReq("R10", 16'h0010, 1, 0, 255, 4'h2, 1, 0, 0);
    runReq("R10", 16'h0010, 2, 0, 255, 4'h2, 1, 0, 0);
    runReq("R10", 16'h0010, 1, 0, 255, 4'h0, 1, 0, 0);
    runReq("R10", 16'h0010, 7, 0, 255, 4'h1, 0, 0, 0);
    // R2 random mix over all fields
    for (int i = 0; i < 600; i++) begin
      logic [15:0] sel;
      int lim;
      sel = ($urandom_range(0, 3) == 0) ? 16'($urandom_range(0, 7))
                                       : 16'($urandom_range(0, 16'h01FF));
      lim = ($urandom_range(0, 1) == 0) ? int'($urandom_range(0, 16'h0FFF))
                                       : int'($urandom_range(0, 16'hFFFF));
      runReq("R2", sel, int'($urandom_range(0, 7)), int'($urandom_range(0, 3)), lim,
        4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)),
        int'($urandom_range(0, 3)), 1'($urandom_range(0, 3) != 0));
    end
    @(negedge clk);
    check("R1", !resValid && faultSel == 0,
      $sformatf("idle after requests actual valid=%b expected=0", resValid));
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule